// File: doc/BRIEF.md
# Wide-to-Narrow Dual-Clock FIFO Channel

This block carries 36-bit words from a write clock domain to an independent read clock domain. On the read side each word comes out as two 18-bit half-words. The two clocks may be unrelated or may be the same clock. A 16-word memory holds the data. The write and read pointers cross between the domains as gray codes through two-flop synchronizers.

One configuration pin does two jobs. While reset is held, it sets the half-word order. Right after reset, it sets the read timing. In standard timing, a qualified read loads the next half-word into the output register, and the flag means "data stored". In fall-through timing, the next half-word is already on the output, and the flag means "output valid". The flag, a programmable almost-empty indication on the read side and a full indication on the write side are all registered outputs. The almost-empty threshold is taken from a parallel input during reset. Reset is synchronous and active high, and it is held for several edges of both clocks.

Top module: `w2n_cdc_fifo`

## Requirements
- R1: Each accepted 36-bit word is delivered as exactly two consecutive 18-bit half-words. Words leave in the order they were written, and no word is lost or repeated.
- R2: `cfg_pin` is sampled at the last read-clock edge of reset. When it is 1, bits [35:18] of each word come out first. When it is 0, bits [17:0] come out first.
- R3: The level of `cfg_pin` at the first read-clock edge after reset release fixes the read timing: 1 selects standard timing and 0 selects fall-through timing. Later changes on `cfg_pin` have no effect until the next reset.
- R4: In standard timing, `rd_flag` is 1 exactly when at least one undelivered half-word is stored. A qualified read taken while `rd_flag` is 1 places the next half-word on `rd_data` at that same read-clock edge.
- R5: In fall-through timing, `rd_flag` equal to 1 means `rd_data` already holds the next half-word. That value stays stable until a qualified read consumes it.
- R6: `rd_aempty_n` is 0 when the number of undelivered half-words is less than or equal to the `ae_level` value captured during reset, and 1 otherwise. It is registered on the read clock.
- R7: A write happens only on a write-clock edge with `wr_cs_n` = 0 and `wr_en` = 1. A read happens only on a read-clock edge with `rd_cs_n` = 0 and `rd_en` = 1. `rd_oe` is 1 exactly while `rd_cs_n` is 0.
- R8: `wr_full_n` goes to 0 once 16 words are stored. A write attempted while it is 0 is dropped and changes no stored word and no pointer.
- R9: In standard timing, a read attempted while `rd_flag` is 0 leaves `rd_data` unchanged and does not disturb the data written afterwards.
- R10: Each pointer that crosses between the clock domains changes in at most one bit per clock edge.
- R11: After reset, `wr_full_n` = 1, `rd_flag` = 0 and `rd_aempty_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen in both domains |
| cfg_pin | input | 1 | Half-word order during reset, read timing after reset |
| ae_level | input | 6 | Almost-empty threshold in half-words, captured during reset |
| wr_cs_n | input | 1 | Write-port select, active low |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Write word |
| wr_full_n | output | 1 | Low when the memory is full |
| rd_cs_n | input | 1 | Read-port select, active low |
| rd_en | input | 1 | Read enable |
| rd_data | output | 18 | Read half-word |
| rd_oe | output | 1 | Read data output enable |
| rd_flag | output | 1 | Standard: data stored. Fall-through: output valid |
| rd_aempty_n | output | 1 | Low when undelivered half-words are at or below the threshold |

## Verification
The bench runs all four combinations of half-word order and read timing. Each word has distinct upper and lower halves, so a swapped or repeated half shows up as a mismatch. Short bursts with the threshold at 4 check when the almost-empty output switches on each read, and a threshold of 0 checks it at the empty boundary. A 17-word burst against an idle reader checks the full boundary and confirms that the dropped word never comes out. Reads on an empty memory, deselected writes and reads, and a change on the configuration pin after reset are each followed by reads, and those reads show whether the pointers and the captured mode survived.

// File: rtl/w2n_pkg.sv
`timescale 1ns/1ps
package w2n_pkg;
  typedef enum logic {
    RD_STANDARD = 1'b0,
    RD_FALLTHRU = 1'b1
  } rd_timing_e;
endpackage

// File: rtl/w2n_sync2.sv
`timescale 1ns/1ps
module w2n_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/w2n_ram.sv
`timescale 1ns/1ps
module w2n_ram #(
  parameter int DW    = 36,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/w2n_wr_ctrl.sv
`timescale 1ns/1ps
module w2n_wr_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_n,
  input  logic        en,
  input  logic [AW:0] rgray_s,
  output logic        we,
  output logic [AW:0] wbin,
  output logic [AW:0] wgray,
  output logic        full_n
);
  logic [AW:0] rbin;
  logic [AW:0] wnext;

  always_comb begin
    rbin[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_s[i];
  end

  assign we    = !cs_n && en && full_n;
  assign wnext = wbin + {{AW{1'b0}}, we};

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin   <= '0;
      wgray  <= '0;
      full_n <= 1'b1;
    end else begin
      wbin   <= wnext;
      wgray  <= wnext ^ (wnext >> 1);
      full_n <= ((wnext - rbin) != (AW+1)'(DEPTH));
    end
  end
endmodule

// File: rtl/w2n_rd_ctrl.sv
`timescale 1ns/1ps
module w2n_rd_ctrl
  import w2n_pkg::*;
#(
  parameter int DW    = 36,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int HW   = DW / 2,
  localparam int OW   = AW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_pin,
  input  logic [OW-1:0] ofs,
  input  logic          cs_n,
  input  logic          en,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [HW-1:0] data,
  output logic          flag,
  output logic          aempty_n,
  output logic [AW+1:0] hptr,
  output logic          fwft,
  output logic          mode_done
);
  rd_timing_e  mode_q;
  logic        big_q;
  logic        ov_q;
  logic        ne_q;
  logic [OW-1:0] ofs_q;

  logic [AW:0]   wbin_s;
  logic [AW+1:0] avail, avail_n, hnext;
  logic [AW:0]   rword_n;
  logic [AW+2:0] cnt_n;
  logic          go, pop, take, ov_n, sel_hi;
  logic [HW-1:0] half;

  always_comb begin
    wbin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  assign fwft    = (mode_q == RD_FALLTHRU);
  assign go      = !cs_n && en && mode_done;
  assign avail   = {wbin_s, 1'b0} - hptr;
  assign pop     = go && ov_q;
  assign take    = mode_done && (fwft ? ((!ov_q || go) && (avail != '0))
                                      : (go && ne_q));
  assign hnext   = hptr + {{(AW+1){1'b0}}, take};
  assign avail_n = {wbin_s, 1'b0} - hnext;
  assign rword_n = hnext[AW+1:1];
  assign ov_n    = fwft && (take || (ov_q && !pop));
  assign cnt_n   = {1'b0, avail_n} + {{(AW+2){1'b0}}, ov_n};

  assign raddr   = hptr[AW:1];
  assign sel_hi  = big_q ^ hptr[0];
  assign half    = sel_hi ? mem_q[DW-1:HW] : mem_q[HW-1:0];
  assign flag    = fwft ? ov_q : ne_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hptr      <= '0;
      rgray     <= '0;
      ov_q      <= 1'b0;
      ne_q      <= 1'b0;
      aempty_n  <= 1'b0;
      data      <= '0;
      big_q     <= cfg_pin;
      ofs_q     <= ofs;
      mode_q    <= RD_STANDARD;
      mode_done <= 1'b0;
    end else begin
      if (!mode_done) begin
        mode_done <= 1'b1;
        mode_q    <= cfg_pin ? RD_STANDARD : RD_FALLTHRU;
      end
      hptr     <= hnext;
      rgray    <= rword_n ^ (rword_n >> 1);
      ov_q     <= ov_n;
      ne_q     <= (avail_n != '0);
      aempty_n <= (cnt_n > {1'b0, ofs_q});
      if (take) data <= half;
    end
  end
endmodule

// File: rtl/w2n_cdc_fifo.sv
`timescale 1ns/1ps
module w2n_cdc_fifo #(
  parameter int DW    = 36,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int HW   = DW / 2,
  localparam int OW   = AW + 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst,
  input  logic          cfg_pin,
  input  logic [OW-1:0] ae_level,
  input  logic          wr_cs_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full_n,
  input  logic          rd_cs_n,
  input  logic          rd_en,
  output logic [HW-1:0] rd_data,
  output logic          rd_oe,
  output logic          rd_flag,
  output logic          rd_aempty_n
);
  logic          w_we;
  logic [AW:0]   w_bin, w_gray, w_gray_s;
  logic [AW:0]   r_gray, r_gray_s;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] mem_q;
  logic [AW+1:0] r_hptr;
  logic          r_fwft, r_mode_done;

  w2n_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(wr_clk), .rst(rst), .cs_n(wr_cs_n), .en(wr_en),
    .rgray_s(r_gray_s), .we(w_we), .wbin(w_bin), .wgray(w_gray),
    .full_n(wr_full_n)
  );

  w2n_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .wr_clk(wr_clk), .we(w_we), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
    .raddr(r_addr), .rdata(mem_q)
  );

  w2n_sync2 #(.W(AW+1)) u_sync_w2r (
    .clk(rd_clk), .rst(rst), .d(w_gray), .q(w_gray_s)
  );

  w2n_sync2 #(.W(AW+1)) u_sync_r2w (
    .clk(wr_clk), .rst(rst), .d(r_gray), .q(r_gray_s)
  );

  w2n_rd_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst(rst), .cfg_pin(cfg_pin), .ofs(ae_level),
    .cs_n(rd_cs_n), .en(rd_en), .wgray_s(w_gray_s), .mem_q(mem_q),
    .raddr(r_addr), .rgray(r_gray), .data(rd_data), .flag(rd_flag),
    .aempty_n(rd_aempty_n), .hptr(r_hptr), .fwft(r_fwft),
    .mode_done(r_mode_done)
  );

  assign rd_oe = !rd_cs_n;
endmodule

// File: rtl/w2n_cdc_fifo_chk.sv
`timescale 1ns/1ps
module w2n_cdc_fifo_chk #(
  parameter int AW = 4,
  parameter int HW = 18
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst,
  input logic          wr_cs_n,
  input logic          wr_en,
  input logic          wr_full_n,
  input logic [AW:0]   wbin,
  input logic [AW:0]   wgray,
  input logic          rd_cs_n,
  input logic          rd_en,
  input logic          rd_flag,
  input logic [HW-1:0] rd_data,
  input logic [AW+1:0] hptr,
  input logic [AW:0]   rgray,
  input logic          fwft,
  input logic          mode_done
);
  logic wgo, rgo;
  assign wgo = !wr_cs_n && wr_en;
  assign rgo = !rd_cs_n && rd_en;

  p_full_drop_r8: assert property (@(posedge wr_clk) disable iff (rst)
    (!wr_full_n && wgo) |=> $stable(wbin));

  p_wgray_step_r10: assert property (@(posedge wr_clk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray)));

  p_rgray_step_r10: assert property (@(posedge rd_clk) disable iff (rst)
    $onehot0(rgray ^ $past(rgray)));

  p_mode_held_r3: assert property (@(posedge rd_clk) disable iff (rst)
    mode_done |=> $stable(fwft));

  p_fall_hold_r5: assert property (@(posedge rd_clk) disable iff (rst)
    (mode_done && fwft && rd_flag && !rgo) |=> (rd_flag && $stable(rd_data)));

  p_empty_read_r9: assert property (@(posedge rd_clk) disable iff (rst)
    (mode_done && !fwft && !rd_flag && rgo) |=> ($stable(hptr) && $stable(rd_data)));
endmodule

bind w2n_cdc_fifo w2n_cdc_fifo_chk #(.AW(AW), .HW(HW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
  .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_full_n(wr_full_n),
  .wbin(w_bin), .wgray(w_gray),
  .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_flag(rd_flag), .rd_data(rd_data),
  .hptr(r_hptr), .rgray(r_gray), .fwft(r_fwft), .mode_done(r_mode_done)
);

// File: tb/w2n_cdc_fifo_bench.sv
`timescale 1ns/1ps
module w2n_cdc_fifo_bench;
  logic        wr_clk = 1'b0;
  logic        rd_clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_pin = 1'b1;
  logic [5:0]  ae_level = '0;
  logic        wr_cs_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic        wr_full_n;
  logic        rd_cs_n = 1'b1;
  logic        rd_en = 1'b0;
  logic [17:0] rd_data;
  logic        rd_oe;
  logic        rd_flag;
  logic        rd_aempty_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic [17:0] exp_q[$];
  bit big_exp;
  bit fwft_exp;

  always #10 wr_clk = ~wr_clk;
  always #17 rd_clk = ~rd_clk;

  w2n_cdc_fifo u_w2n_cdc_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .cfg_pin(cfg_pin),
    .ae_level(ae_level), .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full_n(wr_full_n), .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_oe(rd_oe), .rd_flag(rd_flag), .rd_aempty_n(rd_aempty_n)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act,
                     input logic [35:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit endian, input bit mode, input logic [5:0] lvl);
    rst = 1'b1; cfg_pin = endian; ae_level = lvl;
    wr_cs_n = 1'b1; wr_en = 1'b0; rd_cs_n = 1'b1; rd_en = 1'b0;
    repeat (5) @(posedge rd_clk);
    repeat (5) @(posedge wr_clk);
    @(negedge rd_clk);
    rst = 1'b0; cfg_pin = mode;
    exp_q.delete();
    big_exp = endian; fwft_exp = !mode;
    repeat (3) @(negedge rd_clk);
  endtask

  // driver: one write attempt, expected half-words queued when accepted
  task automatic write_word(input logic [35:0] w, input bit cs_n, input bit en,
                            output bit acc);
    @(negedge wr_clk);
    acc = wr_full_n && !cs_n && en;
    wr_data = w; wr_cs_n = cs_n; wr_en = en;
    @(negedge wr_clk);
    wr_cs_n = 1'b1; wr_en = 1'b0;
    if (acc) begin
      if (big_exp) begin exp_q.push_back(w[35:18]); exp_q.push_back(w[17:0]); end
      else         begin exp_q.push_back(w[17:0]);  exp_q.push_back(w[35:18]); end
    end
  endtask

  // monitor: wait for data, read one half-word, compare with queue head
  task automatic read_half(input string req);
    logic [17:0] seen, got, exp;
    int n;
    n = 0;
    @(negedge rd_clk);
    while (!rd_flag && n < 500) begin @(negedge rd_clk); n++; end
    if (!rd_flag) begin chk(1'b0, {req, " no data"}, 36'(rd_flag), 36'd1); return; end
    seen = rd_data;
    rd_cs_n = 1'b0; rd_en = 1'b1;
    @(negedge rd_clk);
    rd_cs_n = 1'b1; rd_en = 1'b0;
    got = fwft_exp ? seen : rd_data;
    if (exp_q.size() == 0) chk(1'b0, {req, " unexpected"}, 36'(got), 36'd0);
    else begin
      exp = exp_q.pop_front();
      chk(got == exp, req, 36'(got), 36'(exp));
    end
  endtask

  initial begin
    #(20 * 100000);
    chk(1'b0, "watchdog", 36'd0, 36'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit acc;
    logic [17:0] last;
    int nacc;

    // big order, standard timing, threshold 4
    do_reset(1'b1, 1'b1, 6'd4);
    chk(wr_full_n == 1'b1, "R11 full_n", 36'(wr_full_n), 36'd1);
    chk(rd_flag == 1'b0, "R11 flag", 36'(rd_flag), 36'd0);
    chk(rd_aempty_n == 1'b0, "R11 aempty_n", 36'(rd_aempty_n), 36'd0);
    chk(rd_oe == 1'b0, "R7 oe deselected", 36'(rd_oe), 36'd0);
    write_word(36'h1_1111_2222, 1'b1, 1'b1, acc);
    write_word(36'h3_3333_4444, 1'b0, 1'b0, acc);
    repeat (12) @(negedge rd_clk);
    chk(rd_flag == 1'b0, "R7 unqualified writes", 36'(rd_flag), 36'd0);
    write_word(36'hA_BCDE_1234, 1'b0, 1'b1, acc);
    write_word(36'h5_6789_ABCD, 1'b0, 1'b1, acc);
    write_word(36'hC_0FFE_E00D, 1'b0, 1'b1, acc);
    repeat (12) @(negedge rd_clk);
    chk(rd_flag == 1'b1, "R4 flag with data", 36'(rd_flag), 36'd1);
    chk(rd_aempty_n == 1'b1, "R6 six above four", 36'(rd_aempty_n), 36'd1);
    read_half("R2 big first half std");
    chk(rd_aempty_n == 1'b1, "R6 five above four", 36'(rd_aempty_n), 36'd1);
    read_half("R1 second half std");
    chk(rd_aempty_n == 1'b0, "R6 four at threshold", 36'(rd_aempty_n), 36'd0);
    repeat (4) read_half("R1 drain std");
    chk(rd_flag == 1'b0, "R4 flag drained", 36'(rd_flag), 36'd0);
    @(negedge rd_clk);
    last = rd_data;
    rd_cs_n = 1'b0; rd_en = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_cs_n = 1'b1; rd_en = 1'b0;
    chk(rd_data == last, "R9 empty read data", 36'(rd_data), 36'(last));
    chk(rd_flag == 1'b0, "R9 empty read flag", 36'(rd_flag), 36'd0);
    write_word(36'h7_7654_3210, 1'b0, 1'b1, acc);
    repeat (12) @(negedge rd_clk);
    last = rd_data;
    rd_cs_n = 1'b1; rd_en = 1'b1;
    repeat (3) @(negedge rd_clk);
    chk(rd_data == last, "R7 deselected read", 36'(rd_data), 36'(last));
    chk(rd_oe == 1'b0, "R7 oe off", 36'(rd_oe), 36'd0);
    rd_cs_n = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge rd_clk);
    chk(rd_oe == 1'b1, "R7 oe on", 36'(rd_oe), 36'd1);
    chk(rd_data == last, "R7 disabled read", 36'(rd_data), 36'(last));
    rd_cs_n = 1'b1;
    read_half("R9 data after empty read");
    read_half("R9 second half after empty read");

    // little order, fall-through timing, threshold 0
    do_reset(1'b0, 1'b0, 6'd0);
    chk(rd_flag == 1'b0, "R11 flag fwft", 36'(rd_flag), 36'd0);
    write_word(36'h2_4681_3579, 1'b0, 1'b1, acc);
    write_word(36'h9_8765_FEDC, 1'b0, 1'b1, acc);
    cfg_pin = 1'b1;
    repeat (12) @(negedge rd_clk);
    chk(rd_flag == 1'b1, "R5 valid without read", 36'(rd_flag), 36'd1);
    chk(rd_data == 18'(36'h2_4681_3579), "R3 R5 head shown, pin change ignored",
        36'(rd_data), 36'(18'(36'h2_4681_3579)));
    last = rd_data;
    repeat (4) @(negedge rd_clk);
    chk(rd_data == last, "R5 head held", 36'(rd_data), 36'(last));
    chk(rd_aempty_n == 1'b1, "R6 above zero", 36'(rd_aempty_n), 36'd1);
    repeat (4) read_half("R2 little order fwft");
    repeat (3) @(negedge rd_clk);
    chk(rd_flag == 1'b0, "R5 not valid when empty", 36'(rd_flag), 36'd0);
    chk(rd_aempty_n == 1'b0, "R6 zero at zero", 36'(rd_aempty_n), 36'd0);

    // big order, fall-through, fill past full
    do_reset(1'b1, 1'b0, 6'd0);
    nacc = 0;
    for (int i = 0; i < 17; i++) begin
      write_word({4'(i), 14'(i * 3 + 1), 4'(15 - i), 14'(i * 5 + 2)}, 1'b0, 1'b1, acc);
      if (acc) nacc++;
    end
    chk(nacc == 16, "R8 accepted count", 36'(nacc), 36'd16);
    chk(wr_full_n == 1'b0, "R8 full_n low", 36'(wr_full_n), 36'd0);
    repeat (32) read_half("R8 R1 drain after full");
    repeat (10) @(negedge rd_clk);
    chk(rd_flag == 1'b0, "R8 dropped word absent", 36'(rd_flag), 36'd0);
    chk(wr_full_n == 1'b1, "R8 full_n released", 36'(wr_full_n), 36'd1);

    // little order, standard timing
    do_reset(1'b0, 1'b1, 6'd1);
    write_word(36'hF_0000_0001, 1'b0, 1'b1, acc);
    write_word(36'h0_FFFF_FFFE, 1'b0, 1'b1, acc);
    repeat (4) read_half("R2 little order std");
    repeat (3) @(negedge rd_clk);
    chk(rd_flag == 1'b0, "R4 flag after std drain", 36'(rd_flag), 36'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule